// File: doc/BRIEF.md
# Right-to-Left Montgomery Modular Exponentiator

This block raises a base to an exponent modulo an odd modulus, with every modular product done as a Montgomery product, so the datapath never divides. The caller presents the base, the exponent, the modulus and the constant R² mod M together with a one-cycle start pulse. R is 2^(W+1). The caller computes this constant and supplies it. The block reports the answer with a one-cycle done pulse.

Inside, two bit-serial Montgomery multipliers run side by side. The first phase moves the base into the Montgomery domain and forms the Montgomery image of 1 at the same time. The loop then handles one exponent bit per pass. In each pass one multiplier squares the running power while the other multiplies it into the accumulator. The accumulator takes the product only when the current exponent bit is set, and the multiply uses the power from before the squaring. The square is kept only while exponent bits remain. A last Montgomery product with 1 brings the accumulator back to the normal domain.

Top module: `mont_exp_r2l`

## Requirements
- R1: An accepted start with odd modulus M ≥ 3 and r2_mod = 2^(2W+2) mod M yields result = base^expo mod M, and the result is always below M.
- R2: An exponent of 0 yields a result of 1.
- R3: done is high for exactly one cycle per operation. result keeps its value from that cycle until the next operation completes.
- R4: A start pulse that arrives while an operation is running is ignored. Its operands have no effect on the result or the timing of the running operation.
- R5: After reset, done is low and result is zero.
- R6: With W = 32, base 2, exponent 1027, modulus 637 and the matching r2_mod, the result is 37.
- R7: A base equal to or larger than the modulus is reduced correctly.
- R8: The controller moves through its phases in a fixed order: conversion load, conversion, loop load, loop pass (the loop load and loop pass repeat once per exponent bit), final load, final conversion, then idle.
- R9: When the exponent has k significant bits, done rises exactly 2W+8+k·(W+3) clock edges after start is sampled, counting the edge that samples start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the block is idle |
| base | input | W | Base operand |
| expo | input | W | Exponent |
| modulus | input | W | Odd modulus, at least 3 |
| r2_mod | input | W | 2^(2W+2) mod modulus |
| result | output | W | base^expo mod modulus |
| done | output | 1 | One-cycle pulse when result is valid |

## Verification
The hardest case to reach from the ports is a second start pulse landing in the middle of a loop pass. It could corrupt the latched modulus or exponent while both multipliers are partway through. The bench fires a start with different operands about a dozen cycles into each of several operations. It then checks that both the result and the exact cycle count of the first operation are unchanged. The cycle count depends on the exponent's bit length, so a skipped or doubled loop pass shows up even when the value happens to agree.

// File: rtl/mont_exp_r2l.sv
module mont_exp_r2l #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] base,
  input  logic [W-1:0] expo,
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] r2_mod,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int AW = W + 2;
  localparam int CW = $clog2(W + 2) + 1;
  localparam logic [CW-1:0] LAST = CW'(W + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LDC, S_CONV, S_LDL, S_LOOP, S_LDF, S_FIN
  } st_t;

  st_t          st;
  logic [W-1:0] m_q, e_q, acc, sq;
  logic [W-1:0] xa, xb, ya, yb;
  logic [AW-1:0] xt, yt;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] mstep(input logic [AW-1:0] t, input logic abit,
                                          input logic [W-1:0] b, input logic [W-1:0] m);
    logic [AW-1:0] s;
    s = t + (abit ? {2'b00, b} : '0);
    s = s + (s[0] ? {2'b00, m} : '0);
    return s >> 1;
  endfunction

  wire [AW-1:0] xn = mstep(xt, xa[0], xb, m_q);
  wire [AW-1:0] yn = mstep(yt, ya[0], yb, m_q);
  wire [AW-1:0] xs = xt - {2'b00, m_q};
  wire [AW-1:0] ys = yt - {2'b00, m_q};
  wire [W-1:0]  xr = (xt >= {2'b00, m_q}) ? xs[W-1:0] : xt[W-1:0];
  wire [W-1:0]  yr = (yt >= {2'b00, m_q}) ? ys[W-1:0] : yt[W-1:0];
  wire          stepping = (cnt != LAST);
  wire [W-1:0]  e_nx = e_q >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; result <= '0;
      m_q <= '0; e_q <= '0; acc <= '0; sq <= '0;
      xa <= '0; xb <= '0; ya <= '0; yb <= '0;
      xt <= '0; yt <= '0; cnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          m_q <= modulus; e_q <= expo;
          xa <= base; xb <= r2_mod;
          ya <= W'(1); yb <= r2_mod;
          st <= S_LDC;
        end
        S_LDC: begin
          xt <= '0; yt <= '0; cnt <= '0; st <= S_CONV;
        end
        S_CONV, S_LOOP, S_FIN: begin
          if (stepping) begin
            xt <= xn; yt <= yn;
            xa <= xa >> 1; ya <= ya >> 1;
            cnt <= cnt + 1'b1;
          end else if (st == S_CONV) begin
            sq <= xr; acc <= yr; st <= S_LDL;
          end else if (st == S_LOOP) begin
            if (e_q[0]) acc <= yr;
            if (e_nx != '0) sq <= xr;
            e_q <= e_nx;
            st <= S_LDL;
          end else begin
            result <= yr; done <= 1'b1; st <= S_IDLE;
          end
        end
        S_LDL: begin
          if (e_q == '0) st <= S_LDF;
          else begin
            xa <= sq; xb <= sq; ya <= acc; yb <= sq;
            xt <= '0; yt <= '0; cnt <= '0;
            st <= S_LOOP;
          end
        end
        S_LDF: begin
          ya <= acc; yb <= W'(1); yt <= '0; cnt <= '0; st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  a_r1_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < m_q));
  a_r4_mod_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(m_q));
  a_r8_conv_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LDC) |=> (st == S_CONV));
  a_r8_fin_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LDF) |=> (st == S_FIN));
  a_r8_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOP) |=> (st == S_LOOP || st == S_LDL));
  a_r8_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (st == S_LDC));
endmodule

// File: tb/mont_exp_r2l_bench.sv
module mont_exp_r2l_bench;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] base = '0, expo = '0, modulus = '0, r2_mod = '0;
  logic [W-1:0] result;
  logic done;
  int checks = 0, bad = 0;
  longint cyc = 0, t0 = 0;
  logic [W-1:0] exp_q[$];
  int lat_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mont_exp_r2l #(.W(W)) u_mont_exp_r2l (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .expo(expo),
    .modulus(modulus), .r2_mod(r2_mod), .result(result), .done(done));

  function automatic logic [W-1:0] ref_pow(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m);
    logic [63:0] r, x;
    r = 64'd1 % m; x = {32'd0, b} % m;
    for (int i = 0; i < W; i++) begin
      if (e[i]) r = (r * x) % m;
      x = (x * x) % m;
    end
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] ref_r2(logic [W-1:0] m);
    logic [63:0] r;
    r = 1;
    for (int i = 0; i < W + 1; i++) r = (r << 1) % m;
    r = (r * r) % m;
    return r[W-1:0];
  endfunction

  function automatic int bitlen(logic [W-1:0] e);
    int k = 0;
    for (int i = 0; i < W; i++) if (e[i]) k = i + 1;
    return k;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: R1 R2 R6 R7 value, R9 latency
  always @(negedge clk) if (rst_n && done) begin
    logic [W-1:0] ev;
    int el;
    if (exp_q.size() == 0) check(1'b0, "R3 unexpected done", 1, 0);
    else begin
      ev = exp_q.pop_front(); el = lat_q.pop_front();
      check(result == ev, "R1/R2/R6/R7 result", result, ev);
      check(cyc - t0 == el, "R9 latency", cyc - t0, el);
    end
  end

  task automatic run(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m, bit poke);
    logic [W-1:0] ev;
    ev = ref_pow(b, e, m);
    exp_q.push_back(ev);
    lat_q.push_back(2 * W + 8 + bitlen(e) * (W + 3));
    @(negedge clk);
    base = b; expo = e; modulus = m; r2_mod = ref_r2(m);
    start = 1'b1; t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R4: start while busy with other operands
      repeat (12) @(negedge clk);
      base = ~b; expo = e ^ 32'h5; modulus = m ^ 32'h6; r2_mod = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    @(negedge clk);
    check(!done, "R3 done width", done, 0);
    repeat (4) @(negedge clk);
    check(result == ev, "R3 result held", result, ev);
    if (poke) check(result == ev, "R4 busy start ignored", result, ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R5 reset done", done, 0);
    check(result == '0, "R5 reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'd2, 32'd1027, 32'd637, 1'b0);         // R6: expect 37
    check(result == 32'd37, "R6 vector", result, 37);
    run(32'd12345, 32'd0, 32'd1001, 1'b0);       // R2
    check(result == 32'd1, "R2 zero exponent", result, 1);
    run(32'hFFFF_FFF0, 32'd77, 32'd251, 1'b0);   // R7 base >= M
    run(32'd5, 32'd1, 32'd3, 1'b0);
    run(32'd0, 32'd9, 32'd97, 1'b0);
    run(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] m, b, e;
      m = $urandom;
      case (i % 3)
        0: m = m & 32'hFF;
        1: m = m & 32'hFFF;
        default: ;
      endcase
      m = m | 32'd1;
      if (m < 3) m = 32'd3;
      b = $urandom;
      e = $urandom >> (i % 29);
      run(b, e, m, (i % 4) == 1);
    end
    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule